// File: doc/BRIEF.md
# BCD Time-of-Day Counter Chain

This block keeps the time of day as four packed-BCD registers: hundredths of a second, seconds, minutes and hours. A 4096 Hz enable pulse drives it. An internal divider turns that pulse into hundredth-of-a-second steps. Each register advances when the register below it wraps. When the hours register wraps, the block emits a one-cycle day carry that the calendar logic consumes.

Software writes the registers through a plain strobe-qualified port, and a fixed mask per register filters each write. Counting then resumes from whatever pattern was stored. A register wraps only when its stored bits match its maximum pattern exactly, so an out-of-range value follows a defined path instead of being corrected. The hours register counts either 00 to 23, or 1 to 12 with an AM/PM flag. A halt flag in the top bit of the seconds register freezes the whole chain.

The write port and the read port carry no stream data. They are plain control pins with no back-pressure. A write is taken on every clock edge where `wr_en` is high. `rd_data` follows `rd_addr` combinationally.

Top module: `tod_bcd_chain`

## Requirements
- R1: After reset, all four registers read 00h, the halt flag is 0 and `day_carry` is 0.
- R2: The hundredths register advances once for every `TICKS_PER_CS` tick pulses, counting 00h..99h in BCD. From 99h it goes to 00h and advances seconds in the same edge.
- R3: Seconds and minutes each count 00h..59h in BCD and wrap to 00h with a carry into the next register. Minutes keep only bits 6:0 of a write.
- R4: Bit 7 of the seconds register (address 1) is the halt flag. While it is 1, no register and no divider phase changes on a tick. A write of AAh reads back as AAh, with 2Ah as the seconds value.
- R5: With hours bit 6 = 0 (24-hour mode), hours count 00h..23h. The step from 23h to 00h raises `day_carry` for exactly one cycle, in the cycle after that edge.
- R6: With hours bit 6 = 1 (12-hour mode; bit 5 = PM, bits 4:0 = BCD hour 1..12), hours step 52h, 41h..49h, 50h, 51h, 72h, 61h..69h, 70h, 71h, 52h. Only the step from 71h to 52h raises `day_carry`.
- R7: Address map: 0 = hundredths (writes keep FFh), 1 = seconds (FFh, where bit 7 is halt), 2 = minutes (7Fh), 3 = hours (7Fh). A read returns the stored value.
- R8: An out-of-range value keeps counting. A low digit of 9 becomes 0 and increments the tens field, which wraps within its own width (hundredths 4 bits, seconds/minutes 3 bits, 24-hour hours 2 bits, 12-hour hours 1 bit). Any other low digit increments modulo 16. A wrap happens only at the exact maximum pattern. Examples: seconds 60h→61h, 5Ah→5Bh; hours 38h→39h→00h with no day carry; hours 7Fh→70h.
- R9: A write beats an increment of the same register in the same cycle, and the written register passes no carry onward in that cycle. A write to hundredths or seconds restarts the divider phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | 4096 Hz enable pulse, one cycle wide |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | Register selected for write |
| wr_data | input | 8 | Write value before masking |
| rd_addr | input | 2 | Register selected for read |
| rd_data | output | 8 | Stored value of the selected register |
| day_carry | output | 1 | One-cycle pulse when hours wrap |

## Verification
The bound checker watches, on every cycle, that `day_carry` lasts one cycle and leaves hours at 00h or 52h. It also checks that a halted chain holds every register, that minutes only move after seconds stood at 59h or after a write, that hundredths only move on a tick, and that a minutes write lands masked. Only the bench scenarios show the full step sequences: every hundredths, seconds, minutes and 24-hour value, and the whole 12-hour AM/PM ring. The bench also covers the defined paths of invalid patterns, the divider restart and the write-versus-tick priority.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam int REG_W = 8;

  typedef enum logic [1:0] {
    ADDR_HUND = 2'd0,
    ADDR_SEC  = 2'd1,
    ADDR_MIN  = 2'd2,
    ADDR_HOUR = 2'd3
  } tod_addr_e;

  localparam logic [REG_W-1:0] HUND_MASK = 8'hFF;
  localparam logic [REG_W-1:0] SEC_MASK  = 8'h7F;
  localparam logic [REG_W-1:0] MIN_MASK  = 8'h7F;
  localparam logic [REG_W-1:0] HOUR_MASK = 8'h7F;

  localparam logic [REG_W-1:0] HUND_MAX  = 8'h99;
  localparam logic [REG_W-1:0] SEC_MAX   = 8'h59;
  localparam logic [REG_W-1:0] MIN_MAX   = 8'h59;
  localparam logic [REG_W-1:0] H24_MAX   = 8'h23;
  localparam logic [REG_W-1:0] H12_MAX   = 8'h71;

  // One BCD step: low digit 9 -> 0 with a tens increment; tens wraps in tens_w bits.
  function automatic logic [REG_W-1:0] bcd_step(input logic [REG_W-1:0] v, input int tens_w);
    logic [3:0] tmask;
    logic [3:0] tens;
    tmask = 4'((1 << tens_w) - 1);
    if (v[3:0] == 4'd9) begin
      tens = (v[7:4] + 4'd1) & tmask;
      return {tens, 4'h0};
    end
    tens = v[7:4] & tmask;
    return {tens, v[3:0] + 4'd1};
  endfunction
endpackage

// File: rtl/tod_tick_div.sv
module tod_tick_div #(
  parameter int TICKS = 41
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic clr,
  output logic step
);
  localparam int PW = (TICKS > 2) ? $clog2(TICKS) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICKS - 1);

  logic [PW-1:0] phase;

  assign step = tick && !clr && (phase == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)     phase <= '0;
    else if (clr)   phase <= '0;
    else if (tick)  phase <= step ? '0 : phase + PW'(1);
  end
endmodule

// File: rtl/tod_bcd_reg.sv
module tod_bcd_reg
  import tod_pkg::*;
#(
  parameter logic [7:0] MASK   = 8'h7F,
  parameter logic [7:0] MAXV   = 8'h59,
  parameter int         TENS_W = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       adv,
  input  logic       wr,
  input  logic [7:0] wdata,
  output logic [7:0] value,
  output logic       carry
);
  logic at_max;

  assign at_max = (value == MAXV);
  assign carry  = adv && !wr && at_max;

  always_ff @(posedge clk) begin
    if (!rst_n)   value <= '0;
    else if (wr)  value <= wdata & MASK;
    else if (adv) value <= at_max ? '0 : bcd_step(value, TENS_W);
  end
endmodule

// File: rtl/tod_hour_reg.sv
module tod_hour_reg
  import tod_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       adv,
  input  logic       wr,
  input  logic [7:0] wdata,
  output logic [7:0] value,
  output logic       wrap
);
  logic       mode12;
  logic       pm;
  logic [7:0] field;
  logic [7:0] fstep;
  logic [7:0] nxt;
  logic       at_max;

  assign mode12 = value[6];
  assign pm     = value[5];
  assign field  = {3'b000, value[4:0]};
  assign fstep  = bcd_step(field, 1);
  assign at_max = mode12 ? (value == H12_MAX) : (value == H24_MAX);
  assign wrap   = adv && !wr && at_max;

  always_comb begin
    if (!mode12) begin
      nxt = at_max ? 8'h00 : bcd_step(value, 2);
    end else if (field == 8'h12) begin
      nxt = {2'b01, pm, 5'h01};
    end else if (field == 8'h11) begin
      nxt = {2'b01, ~pm, 5'h12};
    end else begin
      nxt = {2'b01, pm, fstep[4:0]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)   value <= '0;
    else if (wr)  value <= wdata & HOUR_MASK;
    else if (adv) value <= nxt;
  end
endmodule

// File: rtl/tod_bcd_chain.sv
module tod_bcd_chain
  import tod_pkg::*;
#(
  parameter int TICKS_PER_CS = 41
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       wr_en,
  input  logic [1:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [1:0] rd_addr,
  output logic [7:0] rd_data,
  output logic       day_carry
);
  logic       halt_q;
  logic       run_tick;
  logic       cs_step;
  logic [3:0] wsel;
  logic [7:0] hund_val, sec_val, min_val, hour_val;
  logic       hund_c, sec_c, min_c, hour_wrap;

  genvar gi;
  for (gi = 0; gi < 4; gi++) begin : g_wsel
    assign wsel[gi] = wr_en && (wr_addr == 2'(gi));
  end

  assign run_tick = tick && !halt_q;

  tod_tick_div #(.TICKS(TICKS_PER_CS)) u_div (
    .clk(clk), .rst_n(rst_n), .tick(run_tick),
    .clr(wsel[ADDR_HUND] | wsel[ADDR_SEC]), .step(cs_step)
  );

  tod_bcd_reg #(.MASK(HUND_MASK), .MAXV(HUND_MAX), .TENS_W(4)) u_hund (
    .clk(clk), .rst_n(rst_n), .adv(cs_step), .wr(wsel[ADDR_HUND]),
    .wdata(wr_data), .value(hund_val), .carry(hund_c)
  );

  tod_bcd_reg #(.MASK(SEC_MASK), .MAXV(SEC_MAX), .TENS_W(3)) u_sec (
    .clk(clk), .rst_n(rst_n), .adv(hund_c), .wr(wsel[ADDR_SEC]),
    .wdata(wr_data), .value(sec_val), .carry(sec_c)
  );

  tod_bcd_reg #(.MASK(MIN_MASK), .MAXV(MIN_MAX), .TENS_W(3)) u_min (
    .clk(clk), .rst_n(rst_n), .adv(sec_c), .wr(wsel[ADDR_MIN]),
    .wdata(wr_data), .value(min_val), .carry(min_c)
  );

  tod_hour_reg u_hour (
    .clk(clk), .rst_n(rst_n), .adv(min_c), .wr(wsel[ADDR_HOUR]),
    .wdata(wr_data), .value(hour_val), .wrap(hour_wrap)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      halt_q    <= 1'b0;
      day_carry <= 1'b0;
    end else begin
      if (wsel[ADDR_SEC]) halt_q <= wr_data[7];
      day_carry <= hour_wrap;
    end
  end

  always_comb begin
    unique case (rd_addr)
      ADDR_HUND: rd_data = hund_val;
      ADDR_SEC:  rd_data = {halt_q, sec_val[6:0]};
      ADDR_MIN:  rd_data = min_val;
      default:   rd_data = hour_val;
    endcase
  end
endmodule

// File: rtl/tod_chain_checker.sv
module tod_chain_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       wr_en,
  input logic [1:0] wr_addr,
  input logic [7:0] wr_data,
  input logic       halt,
  input logic [7:0] hund,
  input logic [7:0] sec,
  input logic [7:0] mins,
  input logic [7:0] hour,
  input logic       day_carry
);
  AST_CARRY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    day_carry |=> !day_carry); // R5

  AST_CARRY_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    day_carry |-> (hour == 8'h00 || hour == 8'h52)); // R6

  AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !wr_en) |=> ($stable(hund) && $stable(sec) && $stable(mins) && $stable(hour))); // R4

  AST_MIN_NEEDS_SEC: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(wr_en) && mins != $past(mins)) |-> ($past(sec[6:0]) == 7'h59)); // R3

  AST_HUND_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(wr_en) && hund != $past(hund)) |-> $past(tick)); // R2

  AST_MIN_WRITE_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd2) |=> (mins == ($past(wr_data) & 8'h7F))); // R9
endmodule

bind tod_bcd_chain tod_chain_checker u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .halt(halt_q), .hund(hund_val), .sec(sec_val),
  .mins(min_val), .hour(hour_val), .day_carry(day_carry)
);

// File: tb/tb_tod_bcd_chain.sv
module tb_tod_bcd_chain;
  localparam int TPC = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [7:0] wr_data = 8'h00;
  logic [1:0] rd_addr = 2'd0;
  logic [7:0] rd_data;
  logic       day_carry;

  int  n_checks = 0;
  int  n_fail = 0;
  bit  done = 1'b0;
  bit  saw_carry;

  tod_bcd_chain #(.TICKS_PER_CS(TPC)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .day_carry(day_carry)
  );

  always #2 clk = ~clk;

  function automatic logic [7:0] bcd(input int n);
    return 8'(((n / 10) << 4) | (n % 10));
  endfunction

  function automatic logic [7:0] enc12(input int k);
    int disp;
    disp = (k % 12 == 0) ? 12 : k % 12;
    return 8'h40 | ((k >= 12) ? 8'h20 : 8'h00) | bcd(disp);
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    rd_addr = a;
    #1 v = rd_data;
  endtask

  task automatic pulse_tick();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    if (day_carry) saw_carry = 1'b1;
  endtask

  task automatic advance_cs();
    saw_carry = 1'b0;
    for (int i = 0; i < TPC; i++) pulse_tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, v2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      check("R1 reset value", v, 8'h00);
    end
    check("R1 day_carry", {7'b0, day_carry}, 8'h00);

    // R2 hundredths sweep: 200 steps from 00
    for (int n = 1; n <= 200; n++) begin
      advance_cs();
      rd(2'd0, v);
      check("R2 hundredths", v, bcd(n % 100));
    end
    rd(2'd1, v);
    check("R2 carry into seconds", v, 8'h02);

    // R3 seconds sweep
    for (int s = 0; s < 60; s++) begin
      wr(2'd2, 8'h10);
      wr(2'd1, bcd(s));
      wr(2'd0, 8'h99);
      advance_cs();
      rd(2'd1, v);
      check("R3 seconds", v, bcd((s + 1) % 60));
      rd(2'd2, v);
      check("R3 minute carry", v, (s == 59) ? 8'h11 : 8'h10);
    end
    // R3 minutes sweep
    for (int m = 0; m < 60; m++) begin
      wr(2'd3, 8'h05);
      wr(2'd2, bcd(m));
      wr(2'd1, 8'h59);
      wr(2'd0, 8'h99);
      advance_cs();
      rd(2'd2, v);
      check("R3 minutes", v, bcd((m + 1) % 60));
      rd(2'd3, v);
      check("R3 hour carry", v, (m == 59) ? 8'h06 : 8'h05);
    end

    // R5 24-hour sweep
    for (int h = 0; h < 24; h++) begin
      wr(2'd3, bcd(h));
      wr(2'd2, 8'h59);
      wr(2'd1, 8'h59);
      wr(2'd0, 8'h99);
      advance_cs();
      rd(2'd3, v);
      check("R5 hours 24", v, bcd((h + 1) % 24));
      check("R5 day carry", {7'b0, saw_carry}, (h == 23) ? 8'h01 : 8'h00);
      @(negedge clk);
      check("R5 carry one cycle", {7'b0, day_carry}, 8'h00);
    end

    // R6 12-hour ring
    for (int k = 0; k < 24; k++) begin
      wr(2'd3, enc12(k));
      wr(2'd2, 8'h59);
      wr(2'd1, 8'h59);
      wr(2'd0, 8'h99);
      advance_cs();
      rd(2'd3, v);
      check("R6 hours 12", v, enc12((k + 1) % 24));
      check("R6 day carry", {7'b0, saw_carry}, (k == 23) ? 8'h01 : 8'h00);
    end

    // R7 masks and readback
    wr(2'd2, 8'hFF); rd(2'd2, v); check("R7 minutes mask", v, 8'h7F);
    wr(2'd3, 8'hFF); rd(2'd3, v); check("R7 hours mask", v, 8'h7F);
    wr(2'd0, 8'hA7); rd(2'd0, v); check("R7 hundredths full", v, 8'hA7);

    // R8 invalid patterns
    wr(2'd3, 8'h7F); wr(2'd2, 8'h59); wr(2'd1, 8'h59); wr(2'd0, 8'h99);
    advance_cs(); rd(2'd3, v); check("R8 hours 7F", v, 8'h70);
    wr(2'd3, 8'h38); wr(2'd2, 8'h59); wr(2'd1, 8'h59); wr(2'd0, 8'h99);
    advance_cs(); rd(2'd3, v); check("R8 hours 38", v, 8'h39);
    wr(2'd2, 8'h59); wr(2'd1, 8'h59); wr(2'd0, 8'h99);
    advance_cs(); rd(2'd3, v); check("R8 hours 39", v, 8'h00);
    check("R8 no carry off-path", {7'b0, saw_carry}, 8'h00);
    wr(2'd2, 8'h00); wr(2'd1, 8'h60); wr(2'd0, 8'h99);
    advance_cs(); rd(2'd1, v); check("R8 seconds 60", v, 8'h61);
    rd(2'd2, v); check("R8 no minute carry", v, 8'h00);
    wr(2'd1, 8'h5A); wr(2'd0, 8'h99);
    advance_cs(); rd(2'd1, v); check("R8 seconds 5A", v, 8'h5B);

    // R4 halt
    wr(2'd1, 8'hAA); wr(2'd0, 8'h40);
    rd(2'd1, v); check("R4 halt readback", v, 8'hAA);
    for (int i = 0; i < 4 * TPC; i++) pulse_tick();
    rd(2'd0, v); check("R4 hundredths frozen", v, 8'h40);
    rd(2'd1, v); check("R4 seconds frozen", v, 8'hAA);
    wr(2'd1, 8'h2A); wr(2'd0, 8'h40);
    advance_cs(); rd(2'd0, v); check("R4 resumes", v, 8'h41);

    // R9 phase restart by write
    wr(2'd0, 8'h10);
    for (int i = 0; i < TPC - 1; i++) pulse_tick();
    wr(2'd0, 8'h20);
    for (int i = 0; i < TPC - 1; i++) pulse_tick();
    rd(2'd0, v); check("R9 phase cleared", v, 8'h20);
    pulse_tick();
    rd(2'd0, v); check("R9 step after restart", v, 8'h21);

    // R9 write beats tick on minutes, no carry onward
    wr(2'd3, 8'h04); wr(2'd2, 8'h59); wr(2'd1, 8'h59); wr(2'd0, 8'h99);
    for (int i = 0; i < TPC - 1; i++) pulse_tick();
    @(negedge clk);
    tick = 1'b1; wr_en = 1'b1; wr_addr = 2'd2; wr_data = 8'h33;
    @(negedge clk);
    tick = 1'b0; wr_en = 1'b0;
    rd(2'd2, v);  check("R9 write wins", v, 8'h33);
    rd(2'd3, v2); check("R9 no hour carry", v2, 8'h04);
    rd(2'd1, v);  check("R9 seconds wrapped", v, 8'h00);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule